// File: doc/BRIEF.md
# Link Status Register

This block holds the 16-bit link status word of a serial link port. Two of its bits latch bandwidth-change events reported by the link training logic and stay set until software writes a one to them. The remaining bits either mirror live link-layer state or are fixed.

The live bits are data-link-active, and link training in progress or pending. Training counts as pending when software has requested a retrain and the training state machine has not yet entered Configuration or Recovery. The fixed bits are the common reference clock flag and a placeholder speed code.

The training state machine drives the event and state inputs. A register write port with two byte enables is the only way to clear the sticky bits. The status word is always visible on the output.

Top module: `lnk_stat_reg`

## Requirements
- R1: After reset the status word reads 16'h1001 while `dl_active` is 0 and the state code is neither Configuration nor Recovery.
- R2: Bit 15 becomes 1 on the clock edge after `loc_auto_chg` is high, or after `far_chg` and `far_auto` are both high, provided `dl_down` is low.
- R3: Bit 14 becomes 1 on the clock edge after any of these, provided `dl_down` is low: `loc_fix_chg` is high; `far_chg` is high with `far_auto` low; `retrain_done` is high after a `retrain_wr` pulse that no earlier `retrain_done` has consumed.
- R4: A `retrain_wr` pulse followed by `retrain_done` sets bit 14 even when the state code was already Recovery when the write arrived.
- R5: While `dl_down` is high, no change event sets bit 15 or bit 14.
- R6: A `retrain_done` pulse with no pending `retrain_wr` does not set bit 14.
- R7: With the default `DLA_CAP` = 1, bit 13 equals `dl_active` in the same cycle. With `DLA_CAP` = 0 it reads 0.
- R8: Writes never change bits 13:12 or 10:0. Bit 12 reads 1, bits 10:1 read 0 and bit 0 reads 1.
- R9: Bit 11 reads 1 in the same cycle whenever the state code equals `CFG_CODE` (4'h2) or `RCV_CODE` (4'h3). It also reads 1 from the edge after a `retrain_wr` pulse until the edge at which the state code is seen in one of those two states.
- R10: A write with `wr_en`=1, `wr_be[1]`=1 and a 1 in data bit 15 or 14 clears that bit at the next edge. A 0 data bit, or `wr_be[1]`=0, leaves it unchanged.
- R11: If a set event and a clearing write hit bit 15 or bit 14 in the same cycle, the bit is 1 afterwards.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ltssm_state | input | 4 | Current training state code |
| retrain_wr | input | 1 | One-cycle pulse: software wrote 1 to the retrain control bit |
| retrain_done | input | 1 | One-cycle pulse: a retrain has completed |
| loc_auto_chg | input | 1 | Local autonomous speed/width change, not for reliability |
| loc_fix_chg | input | 1 | Local speed/width change made to correct unreliable operation |
| far_chg | input | 1 | Far end initiated a speed/width change |
| far_auto | input | 1 | Far-end change was flagged autonomous |
| dl_active | input | 1 | Data link control is in its active state |
| dl_down | input | 1 | Data link is in the down state |
| wr_en | input | 1 | Register write strobe |
| wr_be | input | 2 | Byte enables, bit 1 selects bits 15:8 |
| wr_data | input | 16 | Write data |
| stat_q | output | 16 | Status word |

## Verification
The hardest case to reach is a set event arriving in the same cycle as a clearing write, with the bit already in either state. The other inputs in that cycle, such as `dl_down`, can mask the event. The bench reaches it with a sweep over every combination of the five change inputs and the three write-control inputs, from both a preset and a cleared starting value, and predicts each bit arithmetically. Retrain sequencing is driven by ordered pulse scripts. These include a retrain write issued while already in Recovery and a completion that has no matching write.

// File: rtl/lnk_stat_pkg.sv
package lnk_stat_pkg;
  localparam int REG_W   = 16;
  localparam int B_AUTO  = 15;
  localparam int B_BWM   = 14;
  localparam int B_DLA   = 13;
  localparam int B_CLK   = 12;
  localparam int B_TRN   = 11;
  localparam int N_STICKY = 2;

  typedef struct packed {
    logic auto_set;
    logic bwm_set;
  } lnk_evt_t;

  // next value of a write-one-to-clear bit; set has priority
  function automatic logic fn_w1c_next(logic cur, logic set, logic clr);
    return set | (cur & ~clr);
  endfunction

  // a byte-lane qualified clear for one bit position
  function automatic logic fn_lane_clr(logic en, logic [1:0] be,
                                       logic [15:0] d, int pos);
    return en & be[pos/8] & d[pos];
  endfunction
endpackage

// File: rtl/lnk_evt_decode.sv
module lnk_evt_decode
  import lnk_stat_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     retrain_wr,
  input  logic     retrain_done,
  input  logic     loc_auto_chg,
  input  logic     loc_fix_chg,
  input  logic     far_chg,
  input  logic     far_auto,
  input  logic     dl_down,
  output lnk_evt_t evt
);
  logic sw_pend;
  logic far_auto_ev, far_mgmt_ev, sw_done_ev;

  // a software retrain is outstanding until a completion consumes it
  always_ff @(posedge clk) begin
    if (!rst_n)            sw_pend <= 1'b0;
    else if (retrain_wr)   sw_pend <= 1'b1;
    else if (retrain_done) sw_pend <= 1'b0;
  end

  assign far_auto_ev = far_chg & far_auto;
  assign far_mgmt_ev = far_chg & ~far_auto;
  assign sw_done_ev  = retrain_done & sw_pend;

  always_comb begin
    evt.auto_set = ~dl_down & (loc_auto_chg | far_auto_ev);
    evt.bwm_set  = ~dl_down & (loc_fix_chg | far_mgmt_ev | sw_done_ev);
  end

  AST_SWPEND_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    retrain_wr |=> sw_pend); // R4
  AST_SWPEND_USED: assert property (@(posedge clk) disable iff (!rst_n)
    (retrain_done && !retrain_wr) |=> !sw_pend); // R6
endmodule

// File: rtl/lnk_w1c_bit.sv
module lnk_w1c_bit
  import lnk_stat_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q
);
  always_ff @(posedge clk) begin
    if (!rst_n) q <= 1'b0;
    else        q <= fn_w1c_next(q, set_i, clr_i);
  end

  AST_W1C_SET_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q); // R11
  AST_W1C_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q); // R10
  AST_W1C_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_i && !set_i) |=> $stable(q)); // R10
endmodule

// File: rtl/lnk_trn_track.sv
module lnk_trn_track #(
  parameter int              STATE_W  = 4,
  parameter logic [STATE_W-1:0] CFG_CODE = 4'h2,
  parameter logic [STATE_W-1:0] RCV_CODE = 4'h3
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] state,
  input  logic               retrain_wr,
  output logic               trn_o
);
  logic in_trn;
  logic trn_pend;

  function automatic logic fn_in_trn(logic [STATE_W-1:0] s);
    return (s == CFG_CODE) || (s == RCV_CODE);
  endfunction

  assign in_trn = fn_in_trn(state);

  // pending from the retrain write until training is seen to begin
  always_ff @(posedge clk) begin
    if (!rst_n)          trn_pend <= 1'b0;
    else if (retrain_wr) trn_pend <= 1'b1;
    else if (in_trn)     trn_pend <= 1'b0;
  end

  assign trn_o = in_trn | trn_pend;

  AST_PEND_SHOWN: assert property (@(posedge clk) disable iff (!rst_n)
    retrain_wr |=> trn_o); // R9
  AST_PEND_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (in_trn && !retrain_wr) |=> (trn_o == in_trn)); // R9
endmodule

// File: rtl/lnk_stat_reg.sv
module lnk_stat_reg
  import lnk_stat_pkg::*;
#(
  parameter int                 STATE_W  = 4,
  parameter logic [STATE_W-1:0] CFG_CODE = 4'h2,
  parameter logic [STATE_W-1:0] RCV_CODE = 4'h3,
  parameter bit                 DLA_CAP  = 1'b1,
  parameter logic [10:0]        LOW_BITS = 11'h001
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [STATE_W-1:0] ltssm_state,
  input  logic               retrain_wr,
  input  logic               retrain_done,
  input  logic               loc_auto_chg,
  input  logic               loc_fix_chg,
  input  logic               far_chg,
  input  logic               far_auto,
  input  logic               dl_active,
  input  logic               dl_down,
  input  logic               wr_en,
  input  logic [1:0]         wr_be,
  input  logic [15:0]        wr_data,
  output logic [15:0]        stat_q
);
  localparam int STICKY_TOP = B_AUTO;

  lnk_evt_t             evt;
  logic [N_STICKY-1:0]  sticky_set;
  logic [N_STICKY-1:0]  sticky_clr;
  logic [N_STICKY-1:0]  sticky_q;
  logic                 trn_bit;
  logic                 dla_bit;

  lnk_evt_decode u_evt (
    .clk          (clk),
    .rst_n        (rst_n),
    .retrain_wr   (retrain_wr),
    .retrain_done (retrain_done),
    .loc_auto_chg (loc_auto_chg),
    .loc_fix_chg  (loc_fix_chg),
    .far_chg      (far_chg),
    .far_auto     (far_auto),
    .dl_down      (dl_down),
    .evt          (evt)
  );

  // index 1 -> bit 15 (autonomous), index 0 -> bit 14 (management)
  assign sticky_set = {evt.auto_set, evt.bwm_set};

  for (genvar g = 0; g < N_STICKY; g++) begin : g_sticky
    localparam int POS = STICKY_TOP - (N_STICKY - 1) + g;
    assign sticky_clr[g] = fn_lane_clr(wr_en, wr_be, wr_data, POS);
    lnk_w1c_bit u_bit (
      .clk   (clk),
      .rst_n (rst_n),
      .set_i (sticky_set[g]),
      .clr_i (sticky_clr[g]),
      .q     (sticky_q[g])
    );
  end

  lnk_trn_track #(
    .STATE_W  (STATE_W),
    .CFG_CODE (CFG_CODE),
    .RCV_CODE (RCV_CODE)
  ) u_trn (
    .clk        (clk),
    .rst_n      (rst_n),
    .state      (ltssm_state),
    .retrain_wr (retrain_wr),
    .trn_o      (trn_bit)
  );

  if (DLA_CAP) begin : g_dla
    assign dla_bit = dl_active;
  end else begin : g_nodla
    assign dla_bit = 1'b0;
  end

  assign stat_q = {sticky_q, dla_bit, 1'b1, trn_bit, LOW_BITS};

  AST_AUTO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_auto_chg && !dl_down) |=> stat_q[B_AUTO]); // R2
  AST_BW_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_fix_chg && !dl_down) |=> stat_q[B_BWM]); // R3
  AST_DOWN_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (dl_down && !stat_q[B_BWM]) |=> !stat_q[B_BWM]); // R5
  AST_CLR_AUTO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be[1] && wr_data[B_AUTO] && !loc_auto_chg && !far_chg)
      |=> !stat_q[B_AUTO]); // R10
  AST_DLA_OFF: assert property (@(posedge clk) disable iff (!rst_n)
    !dl_active |-> !stat_q[B_DLA]); // R7
endmodule

// File: tb/sim_lnk_stat_reg.sv
module sim_lnk_stat_reg;
  localparam int CLK_PER = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  ltssm_state = 4'h0;
  logic        retrain_wr = 0, retrain_done = 0;
  logic        loc_auto_chg = 0, loc_fix_chg = 0, far_chg = 0, far_auto = 0;
  logic        dl_active = 0, dl_down = 0, wr_en = 0;
  logic [1:0]  wr_be = 2'b00;
  logic [15:0] wr_data = 16'h0000;
  logic [15:0] stat_q;

  int n_chk = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_PER/2) clk = ~clk;

  lnk_stat_reg u0 (
    .clk(clk), .rst_n(rst_n), .ltssm_state(ltssm_state),
    .retrain_wr(retrain_wr), .retrain_done(retrain_done),
    .loc_auto_chg(loc_auto_chg), .loc_fix_chg(loc_fix_chg),
    .far_chg(far_chg), .far_auto(far_auto),
    .dl_active(dl_active), .dl_down(dl_down),
    .wr_en(wr_en), .wr_be(wr_be), .wr_data(wr_data), .stat_q(stat_q)
  );

  task automatic check(input logic [15:0] act, input logic [15:0] exp,
                       input string tag);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic quiet();
    retrain_wr = 0; retrain_done = 0; loc_auto_chg = 0; loc_fix_chg = 0;
    far_chg = 0; far_auto = 0; dl_down = 0; wr_en = 0; wr_be = 2'b00;
    wr_data = 16'h0000;
  endtask

  task automatic step();
    @(posedge clk);
    @(negedge clk);
    quiet();
  endtask

  task automatic clear_all();
    wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF;
    step();
  endtask

  initial begin
    #(CLK_PER * 150000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    quiet();
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    check(stat_q, 16'h1001, "R1 reset value");

    // R8: writes of all ones do not move fixed bits
    wr_en = 1; wr_be = 2'b11; wr_data = 16'hFFFF;
    step();
    check(stat_q, 16'h1001, "R8 fixed bits after write");

    // R7: live data-link-active mirror
    dl_active = 1; #1;
    check({15'd0, stat_q[13]}, 16'd1, "R7 dla high");
    dl_active = 0; #1;
    check({15'd0, stat_q[13]}, 16'd0, "R7 dla low");

    // sweep: preset x 5 event inputs x 3 write controls
    for (int v = 0; v < 512; v++) begin
      logic la, lf, fc, fa, dd, we, b1, wd, pre;
      logic s15, s14, clr, e15, e14;
      string tg;
      {pre, la, lf, fc, fa, dd, we, b1, wd} = v[8:0];
      if (pre) begin loc_auto_chg = 1; loc_fix_chg = 1; step(); end
      else clear_all();
      loc_auto_chg = la; loc_fix_chg = lf; far_chg = fc; far_auto = fa;
      dl_down = dd; wr_en = we; wr_be = {b1, 1'b1}; wr_data = {wd, wd, 14'h3FFF};
      step();
      s15 = !dd && (la || (fc && fa));
      s14 = !dd && (lf || (fc && !fa));
      clr = we && b1 && wd;
      e15 = s15 || (pre && !clr);
      e14 = s14 || (pre && !clr);
      if (dd)                    tg = "R5 down masks events";
      else if ((s15 || s14) && clr) tg = "R11 set beats clear";
      else if (s15 || s14)       tg = "R2 R3 event sets";
      else                       tg = "R10 lane clear";
      check({14'd0, stat_q[15:14]}, {14'd0, e15, e14}, tg);
      check(stat_q & 16'h17FF, 16'h1001, "R8 fixed bits in sweep");
    end

    // R6: completion without a retrain write
    clear_all();
    retrain_done = 1; step();
    check({15'd0, stat_q[14]}, 16'd0, "R6 stray completion");

    // R3: normal retrain write then completion
    retrain_wr = 1; step();
    check({15'd0, stat_q[11]}, 16'd1, "R9 pending after write");
    check({15'd0, stat_q[14]}, 16'd0, "R3 not yet complete");
    repeat (2) step();
    check({15'd0, stat_q[11]}, 16'd1, "R9 pending held");
    ltssm_state = 4'h2; #1;
    check({15'd0, stat_q[11]}, 16'd1, "R9 in configuration");
    step();
    ltssm_state = 4'h0; #1;
    check({15'd0, stat_q[11]}, 16'd0, "R9 cleared after training");
    retrain_done = 1; step();
    check({15'd0, stat_q[14]}, 16'd1, "R3 retrain complete sets");

    // R4: retrain write while already in Recovery
    clear_all();
    ltssm_state = 4'h3;
    retrain_wr = 1; step();
    check({15'd0, stat_q[11]}, 16'd1, "R9 recovery shows training");
    step();
    retrain_done = 1; step();
    check({15'd0, stat_q[14]}, 16'd1, "R4 write during recovery");
    ltssm_state = 4'h0; step();
    check({15'd0, stat_q[11]}, 16'd0, "R9 idle after recovery");

    // R9: every state code without a pending write
    for (int s = 0; s < 16; s++) begin
      ltssm_state = s[3:0]; #1;
      check({15'd0, stat_q[11]}, {15'd0, (s == 2 || s == 3)}, "R9 state decode");
    end
    ltssm_state = 4'h0;

    // R10: clear blocked when upper lane disabled
    loc_auto_chg = 1; step();
    wr_en = 1; wr_be = 2'b01; wr_data = 16'hFFFF; step();
    check({15'd0, stat_q[15]}, 16'd1, "R10 lane disabled keeps bit");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule